// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block is the command side of a PC-style keyboard controller. A host writes bytes to two byte-wide ports: a command port and a data port. It reads status from the command port. The decoder interprets command bytes and holds the controller mode byte, the self-test flag and the output port register. It drives an address-gate line and a one-cycle system reset request from that state.

Some commands are carried out at once. Others only arm a one-deep deferred target for the next data-port byte. That target is the mode byte, the output port, a reply queued as if from the keyboard or from the aux device, or the mouse transmit path. Bytes that the controller answers with leave on a push interface tagged keyboard or aux, for a separate output-buffer arbiter. Plain data bytes and mouse-bound bytes leave on two transmit strobes toward the serial link logic. A command whose upper nibble is all ones is a pulse command: its bit 0 alone chooses between a reset request and doing nothing.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: Once reset is released, the mode byte is 0x03 and the output port holds 0xCF (so the address gate is high). No strobe is active. The status byte reads 0x18 while both buffer-full inputs are low.
- R2: The status byte is formed as follows, each bit taken as stated:
  - bit 0 follows `obf_in`.
  - bit 5 follows `aux_obf_in`.
  - bits 3 and 4 are always 1.
  - bit 2 is the self-test flag.
  - bits 1, 6 and 7 are 0.
- R3: Three query commands each push one reply with the keyboard tag (`reply_aux`=0). Command 0x20 pushes the mode byte, 0xD0 pushes the output port, and 0xC0 pushes 0x80. The push appears in the cycle after the write.
- R4: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9 and 0xAB each push 0x00.
- R5: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 push nothing. Each one routes the next data-port byte as follows:
  - 0x60: into the mode byte.
  - 0xD1: into the output port.
  - 0xD2: out as a keyboard-tagged reply.
  - 0xD3: out as an aux-tagged reply (`reply_aux`=1).
  - 0xD4: out on the mouse transmit strobe.
- R6: Any data-port write clears the deferred target, whatever it was. Commands that do not arm a target leave an armed target in place.
- R7: A data byte written with no deferred target goes out on the keyboard transmit strobe and clears mode bit 4. A byte routed to the mouse clears mode bit 5. Only one of `reply_push`, `kbd_tx_valid`, `aux_tx_valid` and `bad_cmd` pulses per write.
- R8: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R9: Command 0xDD clears output-port bit 1 and command 0xDF sets it. `a20_gate` follows that bit.
- R10: A command with bits 7:4 equal to 0xF whose bit 0 is 0 gives a one-cycle `sys_reset_req`. If its bit 0 is 1, the command changes nothing.
- R11: A byte written to the output port sets `a20_gate` from its bit 1. It raises `sys_reset_req` for one cycle when its bit 0 is 0.
- R12: A command byte outside the decoded set changes no mode, output-port or deferred state and pushes nothing. It pulses `bad_cmd` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_sel_cmd | input | 1 | 1 selects the command port, 0 the data port |
| host_wdata | input | 8 | Byte written by the host |
| obf_in | input | 1 | Output buffer full, from the arbiter |
| aux_obf_in | input | 1 | Output buffer holds aux data, from the arbiter |
| status_rdata | output | 8 | Status byte, combinational |
| mode_byte | output | 8 | Current controller mode byte |
| reply_push | output | 1 | One-cycle push of a controller reply |
| reply_data | output | 8 | Reply byte |
| reply_aux | output | 1 | Reply tag: 1 aux, 0 keyboard |
| kbd_tx_valid | output | 1 | One-cycle strobe toward the keyboard link |
| kbd_tx_data | output | 8 | Byte toward the keyboard link |
| aux_tx_valid | output | 1 | One-cycle strobe toward the mouse link |
| aux_tx_data | output | 8 | Byte toward the mouse link |
| a20_gate | output | 1 | Address-gate line, output-port bit 1 |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_cmd | output | 1 | One-cycle strobe for an unrecognised command |

## Verification
The embedded properties check several rules on every cycle:
- the deferred target is emptied by any data write;
- pulse commands give exactly the reset outcome that their bit 0 selects;
- deferred-target commands never push;
- an unrecognised command leaves mode and output port untouched;
- at most one outgoing action fires per write.

The byte values that leave the block can only be shown by the bench's scenarios. These are replies carrying the mode byte or output port, the routing of a data byte to the correct destination after an armed target, a target surviving an intervening query, the mode-bit side effects of transmits, and the reset values seen through status and query replies.

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder #(
  parameter logic [7:0] MODE_INIT  = 8'h03,
  parameter logic [7:0] PORT_INIT  = 8'hCF,
  parameter logic [7:0] TEST_REPLY = 8'h55,
  parameter logic [7:0] INPORT_VAL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel_cmd,
  input  logic [7:0] host_wdata,
  input  logic       obf_in,
  input  logic       aux_obf_in,
  output logic [7:0] status_rdata,
  output logic [7:0] mode_byte,
  output logic       reply_push,
  output logic [7:0] reply_data,
  output logic       reply_aux,
  output logic       kbd_tx_valid,
  output logic [7:0] kbd_tx_data,
  output logic       aux_tx_valid,
  output logic [7:0] aux_tx_data,
  output logic       a20_gate,
  output logic       sys_reset_req,
  output logic       bad_cmd
);

  typedef enum logic [2:0] {
    PND_NONE, PND_MODE, PND_PORT, PND_KREP, PND_AREP, PND_MOUSE
  } pend_e;

  pend_e      pend_q;
  logic [7:0] mode_q;
  logic [7:0] port_q;
  logic       selftest_q;

  wire cmd_wr   = host_wr &  host_sel_cmd;
  wire dat_wr   = host_wr & ~host_sel_cmd;
  wire is_pulse = (host_wdata[7:4] == 4'hF);

  assign status_rdata = {2'b00, aux_obf_in, 1'b1, 1'b1, selftest_q, 1'b0, obf_in};
  assign mode_byte    = mode_q;
  assign a20_gate     = port_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q        <= PND_NONE;
      mode_q        <= MODE_INIT;
      port_q        <= PORT_INIT;
      selftest_q    <= 1'b0;
      reply_push    <= 1'b0;
      reply_data    <= 8'h00;
      reply_aux     <= 1'b0;
      kbd_tx_valid  <= 1'b0;
      kbd_tx_data   <= 8'h00;
      aux_tx_valid  <= 1'b0;
      aux_tx_data   <= 8'h00;
      sys_reset_req <= 1'b0;
      bad_cmd       <= 1'b0;
    end else begin
      reply_push    <= 1'b0;
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      sys_reset_req <= 1'b0;
      bad_cmd       <= 1'b0;
      if (cmd_wr) begin
        if (is_pulse) begin
          sys_reset_req <= ~host_wdata[0];
        end else begin
          case (host_wdata)
            8'h20: begin reply_push <= 1'b1; reply_data <= mode_q;     reply_aux <= 1'b0; end
            8'hD0: begin reply_push <= 1'b1; reply_data <= port_q;     reply_aux <= 1'b0; end
            8'hC0: begin reply_push <= 1'b1; reply_data <= INPORT_VAL; reply_aux <= 1'b0; end
            8'hAA: begin
              selftest_q <= 1'b1;
              reply_push <= 1'b1; reply_data <= TEST_REPLY; reply_aux <= 1'b0;
            end
            8'hA9, 8'hAB: begin reply_push <= 1'b1; reply_data <= 8'h00; reply_aux <= 1'b0; end
            8'h60: pend_q <= PND_MODE;
            8'hD1: pend_q <= PND_PORT;
            8'hD2: pend_q <= PND_KREP;
            8'hD3: pend_q <= PND_AREP;
            8'hD4: pend_q <= PND_MOUSE;
            8'hA7: mode_q[5] <= 1'b1;
            8'hA8: mode_q[5] <= 1'b0;
            8'hAD: mode_q[4] <= 1'b1;
            8'hAE: mode_q[4] <= 1'b0;
            8'hDD: port_q[1] <= 1'b0;
            8'hDF: port_q[1] <= 1'b1;
            default: bad_cmd <= 1'b1;
          endcase
        end
      end else if (dat_wr) begin
        pend_q <= PND_NONE;
        case (pend_q)
          PND_NONE: begin
            kbd_tx_valid <= 1'b1;
            kbd_tx_data  <= host_wdata;
            mode_q[4]    <= 1'b0;
          end
          PND_MODE: mode_q <= host_wdata;
          PND_PORT: begin
            port_q        <= host_wdata;
            sys_reset_req <= ~host_wdata[0];
          end
          PND_KREP: begin reply_push <= 1'b1; reply_data <= host_wdata; reply_aux <= 1'b0; end
          PND_AREP: begin reply_push <= 1'b1; reply_data <= host_wdata; reply_aux <= 1'b1; end
          PND_MOUSE: begin
            aux_tx_valid <= 1'b1;
            aux_tx_data  <= host_wdata;
            mode_q[5]    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> pend_q == PND_NONE);

  a_r10_pulse_resets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata[7:4] == 4'hF && !host_wdata[0] |=> sys_reset_req);

  a_r10_pulse_noop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata[7:4] == 4'hF && host_wdata[0]
      |=> !sys_reset_req && !reply_push && $stable(mode_q) && $stable(port_q));

  a_r5_deferred_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (host_wdata == 8'h60 || host_wdata == 8'hD1 || host_wdata == 8'hD2 ||
               host_wdata == 8'hD3 || host_wdata == 8'hD4) |=> !reply_push);

  a_r12_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> $stable(mode_q) && $stable(port_q) && !reply_push && !sys_reset_req);

  a_r9_gate_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata == 8'hDF |=> a20_gate);

  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reply_push, kbd_tx_valid, aux_tx_valid, bad_cmd}));

endmodule

// File: tb/kbc_cmd_decoder_bench.sv
module kbc_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_sel_cmd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       obf_in = 1'b0;
  logic       aux_obf_in = 1'b0;
  logic [7:0] status_rdata, mode_byte, reply_data, kbd_tx_data, aux_tx_data;
  logic       reply_push, reply_aux, kbd_tx_valid, aux_tx_valid;
  logic       a20_gate, sys_reset_req, bad_cmd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  kbc_cmd_decoder u_kbc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel_cmd(host_sel_cmd),
    .host_wdata(host_wdata), .obf_in(obf_in), .aux_obf_in(aux_obf_in),
    .status_rdata(status_rdata), .mode_byte(mode_byte), .reply_push(reply_push),
    .reply_data(reply_data), .reply_aux(reply_aux), .kbd_tx_valid(kbd_tx_valid),
    .kbd_tx_data(kbd_tx_data), .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
    .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .bad_cmd(bad_cmd)
  );

  // row: cmd, byte, push, rdata, raux, ktx, atx, rst, bad, a20, mode, req
  localparam int N = 42;
  localparam logic [35:0] TBL [N] = '{
    {1'b1,8'h20, 1'b1,8'h03,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd3},  // R3
    {1'b1,8'hC0, 1'b1,8'h80,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd3},  // R3
    {1'b1,8'hD0, 1'b1,8'hCF,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd1},  // R1
    {1'b1,8'hAA, 1'b1,8'h55,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd4},  // R4
    {1'b1,8'hA9, 1'b1,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd4},  // R4
    {1'b1,8'hAB, 1'b1,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd4},  // R4
    {1'b1,8'hAD, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h13, 4'd8},  // R8
    {1'b1,8'hA7, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h33, 4'd8},  // R8
    {1'b0,8'h5A, 1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,8'h23, 4'd7},  // R7
    {1'b1,8'hD4, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h23, 4'd5},  // R5
    {1'b0,8'hF4, 1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,1'b0, 1'b1,8'h03, 4'd7},  // R7
    {1'b1,8'h60, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h03, 4'd5},  // R5
    {1'b0,8'h47, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd5},  // R5
    {1'b1,8'h20, 1'b1,8'h47,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd3},  // R3
    {1'b1,8'hD2, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd5},  // R5
    {1'b0,8'hAB, 1'b1,8'hAB,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd5},  // R5
    {1'b1,8'hD3, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd5},  // R5
    {1'b0,8'hCD, 1'b1,8'hCD,1'b1, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd5},  // R5
    {1'b0,8'h11, 1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd6},  // R6
    {1'b1,8'hAD, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h57, 4'd8},  // R8
    {1'b1,8'hAE, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd8},  // R8
    {1'b1,8'hA7, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h67, 4'd8},  // R8
    {1'b1,8'hA8, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd8},  // R8
    {1'b1,8'hDD, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,8'h47, 4'd9},  // R9
    {1'b1,8'hD0, 1'b1,8'hCD,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,8'h47, 4'd9},  // R9
    {1'b1,8'hDF, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd9},  // R9
    {1'b1,8'hD1, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd11}, // R11
    {1'b0,8'hC5, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,8'h47, 4'd11}, // R11
    {1'b1,8'hD0, 1'b1,8'hC5,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,8'h47, 4'd11}, // R11
    {1'b1,8'hD1, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,8'h47, 4'd11}, // R11
    {1'b0,8'hC2, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,1'b0, 1'b1,8'h47, 4'd11}, // R11
    {1'b1,8'hFF, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd10}, // R10
    {1'b1,8'hF0, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,1'b0, 1'b1,8'h47, 4'd10}, // R10
    {1'b1,8'hFE, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,1'b0, 1'b1,8'h47, 4'd10}, // R10
    {1'b1,8'hF3, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd10}, // R10
    {1'b1,8'h42, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b1, 1'b1,8'h47, 4'd12}, // R12
    {1'b1,8'hD0, 1'b1,8'hC2,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd12}, // R12
    {1'b1,8'h60, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd6},  // R6
    {1'b1,8'hA9, 1'b1,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h47, 4'd6},  // R6
    {1'b0,8'h07, 1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h07, 4'd6},  // R6
    {1'b0,8'h3C, 1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,8'h07, 4'd6},  // R6
    {1'b1,8'h20, 1'b1,8'h07,1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,8'h07, 4'd3}   // R3
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [7:0] b);
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = c; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("status after reset", 1, status_rdata, 8'h18);
    chk("mode after reset", 1, mode_byte, 8'h03);
    chk("gate after reset", 1, a20_gate, 1'b1);
    chk("strobes after reset", 1, {reply_push, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd}, 5'b0);

    for (int i = 0; i < N; i++) begin
      logic [35:0] v;
      int rq;
      v = TBL[i];
      rq = int'(v[3:0]);
      wr(v[35], v[34:27]);
      chk($sformatf("row %0d push", i), rq, reply_push, v[26]);
      if (v[26]) begin
        chk($sformatf("row %0d reply", i), rq, reply_data, v[25:18]);
        chk($sformatf("row %0d tag", i), rq, reply_aux, v[17]);
      end
      chk($sformatf("row %0d kbd tx", i), rq, kbd_tx_valid, v[16]);
      if (v[16]) chk($sformatf("row %0d kbd byte", i), rq, kbd_tx_data, v[34:27]);
      chk($sformatf("row %0d aux tx", i), rq, aux_tx_valid, v[15]);
      if (v[15]) chk($sformatf("row %0d aux byte", i), rq, aux_tx_data, v[34:27]);
      chk($sformatf("row %0d reset req", i), rq, sys_reset_req, v[14]);
      chk($sformatf("row %0d bad", i), rq, bad_cmd, v[13]);
      chk($sformatf("row %0d gate", i), rq, a20_gate, v[12]);
      chk($sformatf("row %0d mode", i), rq, mode_byte, v[11:4]);
    end

    // R11/R10 strobes last one cycle only
    wr(1'b1, 8'hF2);
    @(negedge clk);
    chk("reset req one cycle", 10, sys_reset_req, 1'b0);

    // R2 status composition, R4 self-test flag kept
    chk("status selftest", 4, status_rdata, 8'h1C);
    obf_in = 1'b1;
    #1 chk("status obf", 2, status_rdata, 8'h1D);
    aux_obf_in = 1'b1;
    #1 chk("status aux obf", 2, status_rdata, 8'h3D);
    obf_in = 1'b0;
    #1 chk("status aux only", 2, status_rdata, 8'h3C);
    aux_obf_in = 1'b0;

    // R1 second reset clears self-test and restores port
    do_reset();
    chk("status after re-reset", 1, status_rdata, 8'h18);
    chk("mode after re-reset", 1, mode_byte, 8'h03);
    wr(1'b1, 8'hD0);
    chk("port after re-reset", 1, reply_data, 8'hCF);

    // R12 unrecognised command while a target is armed keeps it
    wr(1'b1, 8'hD4);
    wr(1'b1, 8'h01);
    chk("bad while armed", 12, bad_cmd, 1'b1);
    wr(1'b0, 8'hE6);
    chk("armed target survives bad cmd", 12, aux_tx_valid, 1'b1);
    chk("mouse byte", 12, aux_tx_data, 8'hE6);

    finish_run();
  end
endmodule